// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O port that a processor controls through a simple memory-mapped register interface. The interface has an address, write data, a write strobe and combinational read data. Each pin can be an output or an input. Output values come from a data register. Software can write that register whole, or it can change single bits through three write-only alias registers that set, clear or toggle the bits selected by a mask. The pad inputs pass through a two-stage synchronizer. A read of the data register returns the whole port state in one access: output pins return their driven value and input pins return their synchronized pad value.

Every pin has its own interrupt detector. A two-bit trigger code selects low level, high level, rising edge or falling edge. A per-pin any-edge bit overrides that code. Detected events latch into sticky status flags, which software clears by writing ones. A mask register decides which flags reach the single registered interrupt line.

Top module: `gpio_irq_port`

## Requirements
- R1: `pad_oe` bit i equals direction register bit i (offset 0x04; 1 = output, 0 = input), and `pad_out` equals the output data register (offset 0x00, written whole), one cycle after the write.
- R2: A write to offset 0x84 ORs the write data into the data register, a write to 0x88 clears the bits set in the write data, and a write to 0x8C inverts them. Unselected bits keep their value. Reads of these three offsets return zero.
- R3: A read of offset 0x00 returns the data register bit for output pins and the synchronized pad bit for input pins. A read of offset 0x08 returns the synchronized pad bus. A pad change becomes visible after two clock edges.
- R4: Pin i < 16 takes its trigger code from bits [2i+1:2i] of the register at 0x0C. Pin i >= 16 takes its code from bits [2(i-16)+1:2(i-16)] of the register at 0x10.
- R5: Trigger code 0 flags a low synchronized level, 1 a high level, 2 a rising edge and 3 a falling edge. An edge is a difference between the current and the previous synchronized sample. A detection sets the pin's status bit (offset 0x18) one cycle later.
- R6: When a pin's bit in the any-edge register (0x1C) is 1, both rising and falling edges flag that pin and its trigger code is ignored.
- R7: Writing 1 to a status bit at 0x18 clears it. Writing 0 leaves it unchanged. With no detection and no clear, a status bit holds.
- R8: A detection and a clear that reach the same status bit in the same cycle leave the bit set.
- R9: `irq` is a register that holds the OR over all pins of status AND mask (mask register 0x14, 1 = enabled). Status bits latch while their pin is masked.
- R10: Reset clears every register, so while reset is asserted `pad_oe`, `pad_out`, `irq` and all register reads are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pad_in | input | 32 | Pad input values (asynchronous) |
| pad_oe | output | 32 | Pad output enables |
| pad_out | output | 32 | Pad output values |
| irq | output | 1 | Combined interrupt, active high, registered |

## Verification
Assertions check on every cycle the per-pin flag update rules: a detection sets the flag, a detection beats a simultaneous clear, a clear without a detection empties the flag, and an untouched flag holds. They also check that the any-edge override flags every change, that the interrupt line tracks the masked flags one cycle later, that writes to the direction and set registers reach the pads, and that alias reads return zero. Only the bench's scenarios show the things that depend on software sequences and pad stimulus: the split of trigger codes across the two config registers, the behaviour of each trigger code, the synchronizer latency, the mixed port read, and the reset values.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned ADDR_W = 8;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'd0,
    TRIG_HIGH = 2'd1,
    TRIG_RISE = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  localparam logic [ADDR_W-1:0] OFS_DOUT    = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR     = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_PADS    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_TRIG_LO = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_TRIG_HI = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_MASK    = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_FLAG    = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_ANYEDGE = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_SET     = 8'h84;
  localparam logic [ADDR_W-1:0] OFS_CLR     = 8'h88;
  localparam logic [ADDR_W-1:0] OFS_TGL     = 8'h8C;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;

endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect
  import gpio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp,
  input  logic [1:0] code,
  input  logic       any_edge,
  input  logic       clr,
  output logic       flag
);

  logic prev_q;
  logic flag_q;
  logic flag_n;
  logic rise;
  logic fall;
  logic hit;

  assign rise = smp & ~prev_q;
  assign fall = ~smp & prev_q;

  always_comb begin
    if (any_edge) begin
      hit = rise | fall;
    end else begin
      unique case (trig_e'(code))
        TRIG_LOW:  hit = ~smp;
        TRIG_HIGH: hit = smp;
        TRIG_RISE: hit = rise;
        TRIG_FALL: hit = fall;
        default:   hit = 1'b0;
      endcase
    end
    flag_n = hit | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= smp;
      flag_q <= flag_n;
    end
  end

  assign flag = flag_q;

  assert_hit_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);

  assert_hit_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && clr) |=> flag_q);

  assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && clr) |=> !flag_q);

  assert_flag_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !clr) |=> (flag_q == $past(flag_q)));

  assert_any_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (any_edge && (smp != prev_q)) |=> flag_q);

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPIN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  input  logic              bus_we,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_oe,
  output logic [NPIN-1:0]   pad_out,
  output logic              irq
);

  localparam int unsigned HALF = NPIN / 2;

  // reset: asynchronous assertion, synchronous release
  logic rst_m_q;
  logic rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_sn  <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_sn  <= rst_m_q;
    end
  end

  // register state
  logic [NPIN-1:0] dout_q,    dout_n;
  logic [NPIN-1:0] dir_q,     dir_n;
  logic [NPIN-1:0] trig_lo_q, trig_lo_n;
  logic [NPIN-1:0] trig_hi_q, trig_hi_n;
  logic [NPIN-1:0] mask_q,    mask_n;
  logic [NPIN-1:0] anyedge_q, anyedge_n;
  logic            irq_q,     irq_n;
  logic [NPIN-1:0] clr_vec;
  logic [NPIN-1:0] flag_vec;
  logic [NPIN-1:0] pad_s;
  logic [NPIN-1:0] port_val;

  gpio_sync #(.W(NPIN)) u_sync (
    .clk   (clk),
    .rst_n (rst_sn),
    .d     (pad_in),
    .q     (pad_s)
  );

  always_comb begin
    dout_n    = dout_q;
    dir_n     = dir_q;
    trig_lo_n = trig_lo_q;
    trig_hi_n = trig_hi_q;
    mask_n    = mask_q;
    anyedge_n = anyedge_q;
    clr_vec   = '0;
    if (bus_we) begin
      case (bus_addr)
        OFS_DOUT:    dout_n    = bus_wdata;
        OFS_SET:     dout_n    = dout_q | bus_wdata;
        OFS_CLR:     dout_n    = dout_q & ~bus_wdata;
        OFS_TGL:     dout_n    = dout_q ^ bus_wdata;
        OFS_DIR:     dir_n     = bus_wdata;
        OFS_TRIG_LO: trig_lo_n = bus_wdata;
        OFS_TRIG_HI: trig_hi_n = bus_wdata;
        OFS_MASK:    mask_n    = bus_wdata;
        OFS_ANYEDGE: anyedge_n = bus_wdata;
        OFS_FLAG:    clr_vec   = bus_wdata;
        default:     ;
      endcase
    end
    irq_n = |(flag_vec & mask_q);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      dout_q    <= '0;
      dir_q     <= '0;
      trig_lo_q <= '0;
      trig_hi_q <= '0;
      mask_q    <= '0;
      anyedge_q <= '0;
      irq_q     <= 1'b0;
    end else begin
      dout_q    <= dout_n;
      dir_q     <= dir_n;
      trig_lo_q <= trig_lo_n;
      trig_hi_q <= trig_hi_n;
      mask_q    <= mask_n;
      anyedge_q <= anyedge_n;
      irq_q     <= irq_n;
    end
  end

  // per-pin detectors, trigger code picked from the low or high config word
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic [1:0] code;
    if (i < HALF) begin : g_lo
      assign code = trig_lo_q[2*i +: 2];
    end else begin : g_hi
      assign code = trig_hi_q[2*(i-HALF) +: 2];
    end
    gpio_pin_detect u_det (
      .clk      (clk),
      .rst_n    (rst_sn),
      .smp      (pad_s[i]),
      .code     (code),
      .any_edge (anyedge_q[i]),
      .clr      (clr_vec[i]),
      .flag     (flag_vec[i])
    );
  end

  assign port_val = (dout_q & dir_q) | (pad_s & ~dir_q);

  always_comb begin
    case (bus_addr)
      OFS_DOUT:    bus_rdata = port_val;
      OFS_DIR:     bus_rdata = dir_q;
      OFS_PADS:    bus_rdata = pad_s;
      OFS_TRIG_LO: bus_rdata = trig_lo_q;
      OFS_TRIG_HI: bus_rdata = trig_hi_q;
      OFS_MASK:    bus_rdata = mask_q;
      OFS_FLAG:    bus_rdata = flag_vec;
      OFS_ANYEDGE: bus_rdata = anyedge_q;
      default:     bus_rdata = '0;
    endcase
  end

  assign pad_oe  = dir_q;
  assign pad_out = dout_q;
  assign irq     = irq_q;

  assert_oe_follows_dir_R1: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_we && bus_addr == OFS_DIR) |=> (pad_oe == $past(bus_wdata)));

  assert_set_alias_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_we && bus_addr == OFS_SET) |=> ((pad_out & $past(bus_wdata)) == $past(bus_wdata)));

  assert_alias_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_addr == OFS_SET || bus_addr == OFS_CLR || bus_addr == OFS_TGL) |-> (bus_rdata == '0));

  assert_irq_rises_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    (|(flag_vec & mask_q)) |=> irq);

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_sn)
    !(|(flag_vec & mask_q)) |=> !irq);

endmodule

// File: tb/sim_gpio_irq_port.sv
module sim_gpio_irq_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_oe;
  logic [31:0] pad_out;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  gpio_irq_port u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .irq       (irq)
  );

  localparam logic [7:0] A_DOUT = 8'h00, A_DIR = 8'h04, A_PADS = 8'h08,
                         A_TLO = 8'h0C, A_THI = 8'h10, A_MASK = 8'h14,
                         A_FLAG = 8'h18, A_ANY = 8'h1C, A_SET = 8'h84,
                         A_CLR = 8'h88, A_TGL = 8'h8C;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic pads(input logic [31:0] v);
    @(negedge clk);
    pad_in = v;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rst_n = 1'b0;
    cyc(3);
    chk("R10", "pad_oe in reset", pad_oe, '0);
    chk("R10", "pad_out in reset", pad_out, '0);
    chk("R10", "irq in reset", {31'd0, irq}, '0);
    rd(A_DIR, v);  chk("R10", "dir in reset", v, '0);
    rd(A_FLAG, v); chk("R10", "status in reset", v, '0);
    rd(A_MASK, v); chk("R10", "mask in reset", v, '0);
    rst_n = 1'b1;
    cyc(8);
    // default code 0 is low level and the pads are low: every pin flags
    rd(A_FLAG, v); chk("R5", "low-level default flags", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_data();
    logic [31:0] v;
    wr(A_DIR, 32'h0000_FFFF);
    wr(A_DOUT, 32'h1234_5678);
    chk("R1", "pad_oe", pad_oe, 32'h0000_FFFF);
    chk("R1", "pad_out", pad_out, 32'h1234_5678);
    pads(32'hABCD_0000);
    rd(A_PADS, v); chk("R3", "pads after one edge", v, 32'h0000_0000);
    rd(A_PADS, v); chk("R3", "pads after two edges", v, 32'hABCD_0000);
    rd(A_DOUT, v); chk("R3", "mixed port read", v, 32'hABCD_5678);
  endtask

  task automatic t_alias();
    logic [31:0] v;
    wr(A_SET, 32'h0000_000F);
    chk("R2", "set alias", pad_out, 32'h1234_567F);
    wr(A_CLR, 32'h1000_0000);
    chk("R2", "clear alias", pad_out, 32'h0234_567F);
    wr(A_TGL, 32'hFF00_0000);
    chk("R2", "toggle alias", pad_out, 32'hFD34_567F);
    rd(A_SET, v); chk("R2", "set alias reads zero", v, '0);
    rd(A_TGL, v); chk("R2", "toggle alias reads zero", v, '0);
  endtask

  task automatic t_edges();
    logic [31:0] v;
    pads(32'h0);
    wr(A_TLO, 32'hAAAA_AAAA);
    wr(A_THI, 32'hAAAA_AAAA);
    cyc(4);
    wr(A_FLAG, 32'hFFFF_FFFF);
    rd(A_FLAG, v); chk("R7", "status cleared", v, '0);
    pads(32'h0000_0008);
    cyc(4);
    rd(A_FLAG, v); chk("R5", "rising edge pin 3", v, 32'h0000_0008);
    wr(A_FLAG, 32'h0000_0008);
    pads(32'h0);
    cyc(4);
    rd(A_FLAG, v); chk("R5", "falling ignored by rise code", v, '0);
    // pin 20: code 3 at bits 9:8 of the high config word
    wr(A_THI, 32'hAAAA_ABAA);
    pads(32'h0010_0000);
    cyc(4);
    rd(A_FLAG, v); chk("R4", "pin 20 rise ignored by fall code", v, '0);
    pads(32'h0);
    cyc(4);
    rd(A_FLAG, v); chk("R4", "pin 20 falling edge", v, 32'h0010_0000);
    wr(A_THI, 32'hAAAA_AAAA);
    wr(A_FLAG, 32'hFFFF_FFFF);
  endtask

  task automatic t_level();
    logic [31:0] v;
    // pin 5 code 1 (bits 11:10), pin 9 code 0 (bits 19:18)
    wr(A_TLO, 32'hAAA2_A6AA);
    cyc(2);
    rd(A_FLAG, v); chk("R5", "low level pin 9", v, 32'h0000_0200);
    pads(32'h0000_0020);
    cyc(4);
    rd(A_FLAG, v); chk("R5", "high level pin 5", v, 32'h0000_0220);
    wr(A_FLAG, 32'h0);
    rd(A_FLAG, v); chk("R7", "write of zero keeps flags", v, 32'h0000_0220);
    wr(A_FLAG, 32'h0000_0020);
    rd(A_FLAG, v); chk("R8", "active level beats clear", v, 32'h0000_0220);
    pads(32'h0);
    cyc(4);
    wr(A_FLAG, 32'h0000_0020);
    rd(A_FLAG, v); chk("R7", "clear after level drops", v, 32'h0000_0200);
    wr(A_TLO, 32'hAAAA_AAAA);
    wr(A_FLAG, 32'hFFFF_FFFF);
    rd(A_FLAG, v); chk("R7", "all cleared", v, '0);
  endtask

  task automatic t_anyedge();
    logic [31:0] v;
    wr(A_ANY, 32'h0000_0080);
    pads(32'h0000_0080);
    cyc(4);
    rd(A_FLAG, v); chk("R6", "any-edge rise pin 7", v, 32'h0000_0080);
    wr(A_FLAG, 32'h0000_0080);
    pads(32'h0);
    cyc(4);
    rd(A_FLAG, v); chk("R6", "any-edge fall pin 7", v, 32'h0000_0080);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    chk("R9", "masked flag keeps irq low", {31'd0, irq}, 32'd0);
    rd(A_FLAG, v); chk("R9", "flag latched while masked", v, 32'h0000_0080);
    wr(A_MASK, 32'h0000_0080);
    cyc(2);
    chk("R9", "irq after unmask", {31'd0, irq}, 32'd1);
    wr(A_FLAG, 32'h0000_0080);
    cyc(2);
    chk("R9", "irq after clear", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_data();
    t_alias();
    t_edges();
    t_level();
    t_anyedge();
    t_mask();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule